// File: doc/BRIEF.md
# Global 64-bit Timer with Self-Rearming Comparator

This block is a memory-mapped global timer. A free-running 64-bit counter advances once per clock while its run bit is set. Software sees the counter as two 32-bit halves. One 64-bit comparator raises a sticky pending flag when the counter has reached it. In auto-advance mode the comparator adds a programmed 32-bit step to itself on every match, which gives a periodic tick. The interrupt line is the pending flag gated by an enable register.

Writes to the counter halves, the comparator halves, the step register and the control register are posted. Each one takes effect a fixed number of cycles after the bus write, which models a crossing into a slower timer domain. When a posted write takes effect, it sets its own sticky status bit. Software acknowledges that bit by writing a 1 to it.

Reads are combinational and have no side effects. The counter halves are live values and are never latched. Software reads a coherent 64-bit time by reading the upper half, then the lower half, then the upper half again, and repeats until both upper reads agree.

Top module: `glb_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With control bit 0 (run) set, the counter adds one each cycle, and a carry out of the lower half increments the upper half. With run clear, the counter holds. Reads of 0x00 (lower half) and 0x04 (upper half) return the live value.
- R3: A write to 0x00 or 0x04 replaces that counter half exactly 4 cycles after the bus write. In that cycle the counter does not also increment. The same update sets bit 0 (lower) or bit 1 (upper) of the counter write-status register at 0x08.
- R4: Writes to the comparator lower half (0x10), comparator upper half (0x14), step (0x18) and control (0x1C) take effect 4 cycles after the bus write. They set bits 0, 1, 2 and 3 respectively of the global write-status register at 0x28.
- R5: A second write to the same posted register before the first has taken effect cancels the first. Only the later value lands, 4 cycles after the later write.
- R6: Write-status bits stay set until a 1 is written to their position. Writing 0 leaves them unchanged. Writes to 0x20 and 0x24 set no status bit.
- R7: While control bit 1 (compare enable) is set and counter >= comparator (unsigned, 64 bits), the pending flag (bit 0 of 0x20) is set on the next cycle, and it stays set.
- R8: With control bit 2 (auto-advance) set, each matching cycle adds the step to the comparator. With bit 2 clear, the comparator keeps its value.
- R9: Writing 1 to bit 0 of 0x20 clears the pending flag. If a match occurs in the same cycle, the flag stays set.
- R10: `irq` equals the pending flag ANDed with bit 0 of 0x24. The enable takes effect on the cycle after its write.
- R11: While compare enable is clear, the pending flag is never set, whatever the comparator value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: pending flag AND enable |

## Verification
The comparator is swept through eight values that straddle a stopped counter, from three below it to four above it. Each sweep point is checked with a pending-clear in the same cycle, which separates a correct >= test from an off-by-one and from a clear that wrongly wins over a match. A periodic run with a step of 10 checks the exact cycle of the first and second interrupt and the advanced comparator value. A counter preset just below a 32-bit boundary exposes carry faults. Back-to-back writes to the step register separate a restarted delay from a queued or dropped one.

// File: rtl/glb_timer_pkg.sv
package glb_timer_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned CNT_W       = 2 * WORD_W;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned CTRL_W      = 3;
  localparam int unsigned NUM_CH      = 6;
  localparam int unsigned NUM_WORD_CH = 5;

  // posted-write channels; word channels first, control last
  localparam int unsigned CH_CNT_LO = 0;
  localparam int unsigned CH_CNT_HI = 1;
  localparam int unsigned CH_CMP_LO = 2;
  localparam int unsigned CH_CMP_HI = 3;
  localparam int unsigned CH_STEP   = 4;
  localparam int unsigned CH_CTRL   = 5;

  // control bits
  localparam int unsigned CTL_RUN   = 0;
  localparam int unsigned CTL_CMPEN = 1;
  localparam int unsigned CTL_AUTO  = 2;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 8'h04;
  localparam logic [ADDR_W-1:0] A_WST_CNT = 8'h08;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 8'h10;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 8'h14;
  localparam logic [ADDR_W-1:0] A_STEP    = 8'h18;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h1C;
  localparam logic [ADDR_W-1:0] A_INT_ST  = 8'h20;
  localparam logic [ADDR_W-1:0] A_INT_EN  = 8'h24;
  localparam logic [ADDR_W-1:0] A_WST_GLB = 8'h28;

  function automatic logic [ADDR_W-1:0] ch_addr(input int unsigned ch);
    case (ch)
      CH_CNT_LO: return A_CNT_LO;
      CH_CNT_HI: return A_CNT_HI;
      CH_CMP_LO: return A_CMP_LO;
      CH_CMP_HI: return A_CMP_HI;
      CH_STEP:   return A_STEP;
      default:   return A_CTRL;
    endcase
  endfunction

  // counter advance for one cycle
  function automatic logic [CNT_W-1:0] f_tick(input logic [CNT_W-1:0] cnt,
                                              input logic run);
    return run ? cnt + CNT_W'(1) : cnt;
  endfunction

  // comparator match condition
  function automatic logic f_match(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] cmp,
                                   input logic en);
    return en && (cnt >= cmp);
  endfunction

  // comparator re-arm by the step value
  function automatic logic [CNT_W-1:0] f_advance(input logic [CNT_W-1:0] cmp,
                                                 input logic [WORD_W-1:0] step);
    return cmp + {{(CNT_W-WORD_W){1'b0}}, step};
  endfunction
endpackage

// File: rtl/glb_timer_commit.sv
module glb_timer_commit #(
  parameter int unsigned DELAY = 4,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          fire,
  output logic [DW-1:0] dout
);
  localparam int unsigned CW = $clog2(DELAY + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      dout   <= '0;
    end else if (load) begin
      left_q <= CW'(DELAY);
      dout   <= din;
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
    end
  end

  // a fresh load in the last cycle restarts the window instead of landing
  assign fire = (left_q == CW'(1)) && !load;
endmodule

// File: rtl/glb_timer_core.sv
module glb_timer_core
  import glb_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fire,
  input  logic [WORD_W-1:0] cnt_lo_d,
  input  logic [WORD_W-1:0] cnt_hi_d,
  input  logic [WORD_W-1:0] cmp_lo_d,
  input  logic [WORD_W-1:0] cmp_hi_d,
  input  logic [WORD_W-1:0] step_d,
  input  logic [CTRL_W-1:0] ctrl_d,
  input  logic              pend_clr,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [WORD_W-1:0] step_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              pend_q,
  output logic              match_ev
);
  logic [CNT_W-1:0] cnt_d, cmp_d;

  assign match_ev = f_match(cnt_q, cmp_q, ctrl_q[CTL_CMPEN]);

  always_comb begin
    if (fire[CH_CNT_LO] || fire[CH_CNT_HI]) begin
      cnt_d = cnt_q;
      if (fire[CH_CNT_LO]) cnt_d[WORD_W-1:0]     = cnt_lo_d;
      if (fire[CH_CNT_HI]) cnt_d[CNT_W-1:WORD_W] = cnt_hi_d;
    end else begin
      cnt_d = f_tick(cnt_q, ctrl_q[CTL_RUN]);
    end
  end

  always_comb begin
    if (fire[CH_CMP_LO] || fire[CH_CMP_HI]) begin
      cmp_d = cmp_q;
      if (fire[CH_CMP_LO]) cmp_d[WORD_W-1:0]     = cmp_lo_d;
      if (fire[CH_CMP_HI]) cmp_d[CNT_W-1:WORD_W] = cmp_hi_d;
    end else if (match_ev && ctrl_q[CTL_AUTO]) begin
      cmp_d = f_advance(cmp_q, step_q);
    end else begin
      cmp_d = cmp_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      step_q <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      if (fire[CH_STEP]) step_q <= step_d;
      if (fire[CH_CTRL]) ctrl_q <= ctrl_d;
      if (match_ev)      pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/glb_timer.sv
module glb_timer
  import glb_timer_pkg::*;
#(
  parameter int unsigned ACK_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  logic [NUM_CH-1:0] load, fire;
  logic [WORD_W-1:0] held [NUM_WORD_CH];
  logic [CTRL_W-1:0] ctrl_held;

  logic [CNT_W-1:0]  cnt_q, cmp_q;
  logic [WORD_W-1:0] step_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              pend_q, match_ev, pend_clr;
  logic              int_en_q;
  logic [1:0]        wst_cnt_q;
  logic [3:0]        wst_glb_q;
  logic              wr_wst_cnt, wr_wst_glb;

  // posted write channels
  for (genvar c = 0; c < NUM_WORD_CH; c++) begin : g_word
    assign load[c] = bus_wr && (bus_addr == ch_addr(c));
    glb_timer_commit #(.DELAY(ACK_DELAY), .DW(WORD_W)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load[c]),
      .din  (bus_wdata),
      .fire (fire[c]),
      .dout (held[c])
    );
  end

  assign load[CH_CTRL] = bus_wr && (bus_addr == A_CTRL);
  glb_timer_commit #(.DELAY(ACK_DELAY), .DW(CTRL_W)) u_dly_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load[CH_CTRL]),
    .din  (bus_wdata[CTRL_W-1:0]),
    .fire (fire[CH_CTRL]),
    .dout (ctrl_held)
  );

  glb_timer_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .cnt_lo_d(held[CH_CNT_LO]),
    .cnt_hi_d(held[CH_CNT_HI]),
    .cmp_lo_d(held[CH_CMP_LO]),
    .cmp_hi_d(held[CH_CMP_HI]),
    .step_d  (held[CH_STEP]),
    .ctrl_d  (ctrl_held),
    .pend_clr(pend_clr),
    .cnt_q   (cnt_q),
    .cmp_q   (cmp_q),
    .step_q  (step_q),
    .ctrl_q  (ctrl_q),
    .pend_q  (pend_q),
    .match_ev(match_ev)
  );

  assign pend_clr   = bus_wr && (bus_addr == A_INT_ST) && bus_wdata[0];
  assign wr_wst_cnt = bus_wr && (bus_addr == A_WST_CNT);
  assign wr_wst_glb = bus_wr && (bus_addr == A_WST_GLB);

  // sticky acknowledge bits: a landing write wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wst_cnt_q <= '0;
      wst_glb_q <= '0;
      int_en_q  <= 1'b0;
    end else begin
      wst_cnt_q <= (wst_cnt_q & ~(wr_wst_cnt ? bus_wdata[1:0] : 2'b00))
                 | fire[CH_CNT_HI:CH_CNT_LO];
      wst_glb_q <= (wst_glb_q & ~(wr_wst_glb ? bus_wdata[3:0] : 4'b0000))
                 | fire[CH_CTRL:CH_CMP_LO];
      if (bus_wr && (bus_addr == A_INT_EN)) int_en_q <= bus_wdata[0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_CNT_LO:  bus_rdata = cnt_q[WORD_W-1:0];
      A_CNT_HI:  bus_rdata = cnt_q[CNT_W-1:WORD_W];
      A_WST_CNT: bus_rdata = {{(WORD_W-2){1'b0}}, wst_cnt_q};
      A_CMP_LO:  bus_rdata = cmp_q[WORD_W-1:0];
      A_CMP_HI:  bus_rdata = cmp_q[CNT_W-1:WORD_W];
      A_STEP:    bus_rdata = step_q;
      A_CTRL:    bus_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
      A_INT_ST:  bus_rdata = {{(WORD_W-1){1'b0}}, pend_q};
      A_INT_EN:  bus_rdata = {{(WORD_W-1){1'b0}}, int_en_q};
      A_WST_GLB: bus_rdata = {{(WORD_W-4){1'b0}}, wst_glb_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = pend_q && int_en_q;
endmodule

// File: rtl/glb_timer_chk.sv
module glb_timer_chk
  import glb_timer_pkg::*;
#(
  parameter int unsigned DELAY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] load,
  input logic [NUM_CH-1:0] fire,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [WORD_W-1:0] step_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              pend_q,
  input logic              match_ev,
  input logic              pend_clr,
  input logic [1:0]        wst_cnt_q,
  input logic [3:0]        wst_glb_q
);
  // R2: counter holds when stopped, steps by one when running
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTL_RUN] && !fire[CH_CNT_LO] && !fire[CH_CNT_HI]) |=> $stable(cnt_q));
  p_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTL_RUN] && !fire[CH_CNT_LO] && !fire[CH_CNT_HI])
      |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R3: counter-half landings set their status bits
  p_ack_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire[CH_CNT_LO] |=> wst_cnt_q[0]);
  p_ack_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire[CH_CNT_HI] |=> wst_cnt_q[1]);

  for (genvar g = 0; g < 4; g++) begin : g_glb
    // R4: comparator, step and control landings set global status bits
    p_ack_glb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire[CH_CMP_LO + g] |=> wst_glb_q[g]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_gap
    logic [31:0] gap_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               gap_q <= '0;
      else if (load[c])                         gap_q <= 32'd1;
      else if (gap_q != '0 && gap_q != '1)      gap_q <= gap_q + 32'd1;
    end
    // R5: a landing comes exactly DELAY cycles after the latest write
    p_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire[c] |-> gap_q == 32'(DELAY));
  end

  // R7: a match sets the pending flag
  p_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> pend_q);

  // R8: auto-advance adds the step on a match
  p_auto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && ctrl_q[CTL_AUTO] && !fire[CH_CMP_LO] && !fire[CH_CMP_HI])
      |=> cmp_q == $past(cmp_q) + {{(CNT_W-WORD_W){1'b0}}, $past(step_q)});

  // R9: a clear without a match drops the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !match_ev) |=> !pend_q);

  // R11: no rise of the flag while comparing is disabled
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTL_CMPEN] && !pend_q) |=> !pend_q);
endmodule

bind glb_timer glb_timer_chk #(.DELAY(ACK_DELAY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load     (load),
  .fire     (fire),
  .cnt_q    (cnt_q),
  .cmp_q    (cmp_q),
  .step_q   (step_q),
  .ctrl_q   (ctrl_q),
  .pend_q   (pend_q),
  .match_ev (match_ev),
  .pend_clr (pend_clr),
  .wst_cnt_q(wst_cnt_q),
  .wst_glb_q(wst_glb_q)
);

// File: tb/glb_timer_bench.sv
`timescale 1ns/1ps
module glb_timer_bench;
  localparam logic [7:0] R_CLO = 8'h00, R_CHI = 8'h04, R_WSC = 8'h08,
                         R_KLO = 8'h10, R_KHI = 8'h14, R_STP = 8'h18,
                         R_CTL = 8'h1C, R_IST = 8'h20, R_IEN = 8'h24,
                         R_WSG = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  glb_timer u_glb_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    logic [7:0] regs [10];
    regs = '{R_CLO, R_CHI, R_WSC, R_KLO, R_KHI, R_STP, R_CTL, R_IST, R_IEN, R_WSG};
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      rd(regs[i], v); check("R1 reset value", v, 0);
    end
    check("R1 irq low", irq, 0);

    // R4 posted step write: lands on the 4th edge
    wr(R_STP, 5); step(3);
    rd(R_WSG, v); check("R4 status not yet", v, 0);
    rd(R_STP, v); check("R4 step not yet", v, 0);
    step(1);
    rd(R_WSG, v); check("R4 status bit2", v, 4);
    rd(R_STP, v); check("R4 step landed", v, 5);

    // R5 restart of the window
    wr(R_WSG, 32'hF);
    wr(R_STP, 9); step(2); wr(R_STP, 11); step(1);
    rd(R_WSG, v); check("R5 first write cancelled status", v, 0);
    rd(R_STP, v); check("R5 first write cancelled value", v, 5);
    step(3);
    rd(R_WSG, v); check("R5 later write landed status", v, 4);
    rd(R_STP, v); check("R5 later write landed value", v, 11);

    // R6 write-one-to-clear and no ack for other registers
    wr(R_WSG, 0);
    rd(R_WSG, v); check("R6 zero write keeps bit", v, 4);
    wr(R_WSG, 4);
    rd(R_WSG, v); check("R6 one write clears bit", v, 0);
    wr(R_IEN, 0); wr(R_IST, 1); step(6);
    rd(R_WSG, v); check("R6 no global ack", v, 0);
    rd(R_WSC, v); check("R6 no counter ack", v, 0);

    // R3 counter-half writes
    wr(R_CLO, 1000); step(3);
    rd(R_CLO, v); check("R3 low not yet", v, 0);
    rd(R_WSC, v); check("R3 status not yet", v, 0);
    step(1);
    rd(R_CLO, v); check("R3 low landed", v, 1000);
    rd(R_WSC, v); check("R3 status bit0", v, 1);
    wr(R_CHI, 0); step(4);
    rd(R_WSC, v); check("R3 status bit1", v, 3);
    wr(R_WSC, 3);
    rd(R_WSC, v); check("R6 counter status cleared", v, 0);

    // R7/R9 sweep of comparator around a stopped counter of 1000
    wr(R_CTL, 2); step(4);
    for (int d = 0; d < 8; d++) begin
      wr(R_KLO, 997 + d); step(4);
      wr(R_IST, 1);
      rd(R_IST, v);
      check("R7 R9 match sweep", v, (1000 >= 997 + d) ? 1 : 0);
    end
    rd(R_CLO, v); check("R2 stopped counter holds", v, 1000);

    // R11 comparing disabled
    wr(R_CTL, 0); step(4);
    wr(R_KLO, 0); step(4);
    wr(R_IST, 1); step(3);
    rd(R_IST, v); check("R11 no pending when disabled", v, 0);

    // R2 running, R3 landing while running
    wr(R_CTL, 1); step(4);
    rd(R_CLO, v); check("R2 run start", v, 1000);
    step(10);
    rd(R_CLO, v); check("R2 ten cycles", v, 1010);
    step(1);
    rd(R_CLO, v2); check("R2 live read advances", v2, v + 1);
    wr(R_CLO, 50); step(4);
    rd(R_CLO, v); check("R3 landing replaces without tick", v, 50);
    step(1);
    rd(R_CLO, v); check("R3 counting resumes", v, 51);

    // R2 carry into upper half
    wr(R_CTL, 0); step(4);
    wr(R_CLO, 32'hFFFF_FFFC); step(4);
    wr(R_CHI, 7); step(4);
    wr(R_CTL, 1); step(4);
    rd(R_CHI, v); check("R2 preset upper", v, 7);
    rd(R_CLO, v); check("R2 preset lower", v, 32'hFFFF_FFFC);
    step(4);
    rd(R_CHI, v); check("R2 carry upper", v, 8);
    rd(R_CLO, v); check("R2 carry lower", v, 0);
    rd(R_CTL, v); check("R4 control readback", v, 1);

    // R7/R8/R10 periodic interrupts, step 10, first compare at 20
    wr(R_CTL, 0); step(4);
    wr(R_CLO, 0); step(4);
    wr(R_CHI, 0); step(4);
    wr(R_KLO, 20); step(4);
    wr(R_STP, 10); step(4);
    wr(R_IEN, 1); wr(R_IST, 1);
    wr(R_CTL, 7);
    step(24);
    rd(R_CLO, v); check("R7 counter at compare", v, 20);
    check("R7 irq not yet", irq, 0);
    step(1);
    check("R7 R10 irq raised", irq, 1);
    rd(R_KLO, v); check("R8 compare advanced", v, 30);
    wr(R_IST, 1);
    check("R9 irq cleared", irq, 0);
    step(8);
    check("R8 no early tick", irq, 0);
    step(1);
    check("R8 second tick", irq, 1);
    rd(R_KLO, v); check("R8 compare advanced again", v, 40);
    wr(R_IEN, 0);
    check("R10 irq gated off", irq, 0);
    rd(R_IST, v); check("R10 pending kept", v, 1);
    wr(R_IEN, 1);
    check("R10 irq back on", irq, 1);

    // R8 off / R9 match priority
    wr(R_CTL, 3); step(4); step(30);
    rd(R_KLO, v);
    wr(R_IST, 1);
    rd(R_IST, v2); check("R9 match wins over clear", v2, 1);
    step(5);
    rd(R_KLO, v2); check("R8 compare fixed without auto", v2, v);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule